// File: doc/BRIEF.md
# Byte-Wide Calendar Clock Memory

This block is a 2048-byte static memory whose top eight bytes serve as the registers of a real-time calendar clock. The host reaches every byte through one SRAM-style port, which is sampled on the system clock. The port has an 11-bit address, separate write and read data buses, and active-low select, read-enable and write-enable strobes. Locations below the clock window are plain storage, and the design is written so that the storage maps onto block RAM.

A hidden chain of packed-BCD counters keeps seconds, minutes, hours, weekday, date, month and a two-digit year. A prescaler counts a tick enable and moves the chain forward one second every `DIV` ticks. `DIV` is 32768 for a 32,768 Hz reference. On each second the new time is copied into the visible clock bytes. A control byte lets the host perform three operations:
- Freeze the visible copy so that a multi-byte read stays coherent.
- Hold the copy while new time values are written, then load those values into the counters.
- Store a signed calibration trim.

A stop flag in the seconds byte halts the time base.

Top module: `bcd_clock_sram`

## Requirements
- R1: Addresses 0x000 to 0x7F7 are read/write storage. A read (select low, read-enable low, write-enable high) returns the byte on `rdata`, with `rdata_oe` high, one clock later. In a cycle after no read, `rdata_oe` is low and `rdata` is 0x00.
- R2: Addresses 0x7F8 to 0x7FF are clock registers that the host reads and writes with the same cycle as storage. The layout is:
  - 0x7F8: control.
  - 0x7F9: seconds, with bit 7 as the stop flag.
  - 0x7FA: minutes.
  - 0x7FB: hours.
  - 0x7FC: weekday.
  - 0x7FD: date.
  - 0x7FE: month.
  - 0x7FF: year.
  
  A write below 0x7F8 never alters a clock register.
- R3: After reset the clock reads 00:00:00, with weekday 01, date 01, month 01, year 00, and control 0x00.
- R4: Every `DIV` ticks of `tick_en` the time advances one second in packed BCD. Seconds and minutes wrap at 59 and hours wrap at 23. The visible bytes are refreshed at each second.
- R5: The date wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other months. February has 29 days when the BCD year is a multiple of 4 and 28 days otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00. Weekday 7 wraps to 1 at midnight.
- R6: While control bit 6 (freeze) is 1, the visible clock bytes keep their values and the counters keep running. After the bit clears, the next second shows the running time.
- R7: While seconds-byte bit 7 (stop) is 1, the prescaler and counters hold and no copy overwrites the visible bytes.
- R8: While control bit 7 (load) is 1, the visible bytes are not refreshed. A host write that takes the bit from 1 to 0 copies the visible time bytes into the counters and restarts the prescaler from zero. The stop flag is not copied.
- R9: Control bits 4:0 give a calibration magnitude M and bit 5 gives its sign. Once in every 64 seconds, one second lasts `DIV`-M ticks when bit 5 is 1, or `DIV`+M ticks when bit 5 is 0.
- R10: The prescaler counts only the cycles in which `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per reference tick |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low read enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW (11) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one clock after the request |
| rdata_oe | output | 1 | High when `rdata` carries read data |

## Verification
The hardest condition to reach from the ports is the single calibrated second that occurs once per 64-second window. Its position depends on a free-running window count that the host cannot see. To reach it, the bench holds a continuous read on the seconds byte for more than 64 seconds and measures the cycle count between successive changes. It then expects exactly one shortened or lengthened interval among 64. Month-end and year-end rollovers are reached by loading times a few seconds before the boundary through the load bit, using both directed cases (leap and non-leap February, 30-day months, year 99) and random near-boundary times.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } caltime_t;

  localparam caltime_t RST_TIME = '{yr: 8'h00, mon: 8'h01, date: 8'h01,
                                    wday: 8'h01, hr: 8'h00, min: 8'h00,
                                    sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // A two-digit year 10*T+U is a multiple of 4 when 2*T+U is.
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic caltime_t tick_time(input caltime_t t);
    caltime_t n;
    n = t;
    if (t.sec < 8'h59) n.sec = bcd_inc(t.sec);
    else begin
      n.sec = 8'h00;
      if (t.min < 8'h59) n.min = bcd_inc(t.min);
      else begin
        n.min = 8'h00;
        if (t.hr < 8'h23) n.hr = bcd_inc(t.hr);
        else begin
          n.hr   = 8'h00;
          n.wday = (t.wday >= 8'h07) ? 8'h01 : bcd_inc(t.wday);
          if (t.date < month_len(t.mon, t.yr)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.mon < 8'h12) n.mon = bcd_inc(t.mon);
            else begin
              n.mon = 8'h01;
              n.yr  = (t.yr >= 8'h99) ? 8'h00 : bcd_inc(t.yr);
            end
          end
        end
      end
    end
    return n;
  endfunction

  // Byte of a time value at register offset idx (offset 0 is control).
  function automatic logic [7:0] time_byte(input caltime_t t, input int idx);
    case (idx)
      1:       return t.sec;
      2:       return t.min;
      3:       return t.hr;
      4:       return t.wday;
      5:       return t.date;
      6:       return t.mon;
      7:       return t.yr;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcdclk_ram.sv
module bcdclk_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single-port, read-first, registered output: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/bcdclk_prescaler.sv
module bcdclk_prescaler #(
  parameter int DIV     = 32768,
  parameter int CAL_WIN = 64,
  parameter int CW      = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          stop,
  input  logic          clear,
  input  logic          cal_fast,
  input  logic [4:0]    cal_mag,
  output logic [CW-1:0] count,
  output logic          sec_pulse
);
  localparam int WW = $clog2(CAL_WIN);
  localparam logic [CW-1:0] NOM = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [WW-1:0] win_q;
  logic [CW-1:0] limit;

  // The first second of each calibration window is trimmed.
  always_comb begin
    if (win_q == '0) limit = cal_fast ? (NOM - CW'(cal_mag)) : (NOM + CW'(cal_mag));
    else             limit = NOM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      win_q     <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (tick_en && !stop) begin
        if (cnt_q >= limit) begin
          cnt_q     <= '0;
          win_q     <= win_q + 1'b1;
          sec_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/bcdclk_chain.sv
module bcdclk_chain
  import bcdclk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     adv,
  input  logic     load,
  input  caltime_t load_val,
  output caltime_t now,
  output caltime_t nxt
);
  caltime_t now_q;

  assign nxt = tick_time(now_q);
  assign now = now_q;

  always_ff @(posedge clk) begin
    if (rst)       now_q <= RST_TIME;
    else if (load) now_q <= load_val;
    else if (adv)  now_q <= nxt;
  end
endmodule

// File: rtl/bcd_clock_sram.sv
module bcd_clock_sram
  import bcdclk_pkg::*;
#(
  parameter int DIV = 32768,
  parameter int AW  = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_oe
);
  localparam int NREG    = 8;
  localparam int OFFW    = $clog2(NREG);
  localparam int CW      = $clog2(DIV + 32) + 1;
  localparam int CAL_WIN = 64;

  logic host_wr, host_rd, creg_hit, creg_wr;
  logic [OFFW-1:0] roff;

  assign host_wr  = !cs_n && !we_n;
  assign host_rd  = !cs_n && !oe_n && we_n;
  assign creg_hit = &addr[AW-1:OFFW];
  assign creg_wr  = host_wr && creg_hit;
  assign roff     = addr[OFFW-1:0];

  logic [NREG-1:0][7:0] creg_v;
  logic [7:0] ctrl, sec_reg, cur_sec;
  logic stop, copy_en, load_stb, sec_pulse;
  logic [CW-1:0] presc_cnt;
  caltime_t now, nxt, load_val;

  assign ctrl     = creg_v[0];
  assign sec_reg  = creg_v[1];
  assign stop     = sec_reg[7];
  assign copy_en  = !ctrl[7] && !ctrl[6];
  assign load_stb = creg_wr && (roff == '0) && ctrl[7] && !wdata[7];
  assign cur_sec  = now.sec;

  assign load_val = '{yr: creg_v[7], mon: creg_v[6], date: creg_v[5],
                      wday: creg_v[4], hr: creg_v[3], min: creg_v[2],
                      sec: creg_v[1] & 8'h7F};

  bcdclk_prescaler #(.DIV(DIV), .CAL_WIN(CAL_WIN), .CW(CW)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .stop     (stop),
    .clear    (load_stb),
    .cal_fast (ctrl[5]),
    .cal_mag  (ctrl[4:0]),
    .count    (presc_cnt),
    .sec_pulse(sec_pulse)
  );

  bcdclk_chain u_chain (
    .clk     (clk),
    .rst     (rst),
    .adv     (sec_pulse),
    .load    (load_stb),
    .load_val(load_val),
    .now     (now),
    .nxt     (nxt)
  );

  // Clock register file: host write wins over the per-second copy.
  for (genvar gi = 0; gi < NREG; gi++) begin : g_creg
    logic [7:0] q;
    logic [7:0] copy_val;
    if (gi == 1) begin : g_sec
      assign copy_val = nxt.sec | {q[7], 7'd0};
    end else begin : g_other
      assign copy_val = time_byte(nxt, gi);
    end
    always_ff @(posedge clk) begin
      if (rst)
        q <= time_byte(RST_TIME, gi);
      else if (creg_wr && roff == OFFW'(gi))
        q <= wdata;
      else if (gi != 0 && sec_pulse && copy_en)
        q <= copy_val;
    end
    assign creg_v[gi] = q;
  end

  logic [7:0] ram_q, creg_q;
  logic rd_q, sel_q;

  bcdclk_ram #(.AW(AW), .DW(8)) u_ram (
    .clk  (clk),
    .we   (host_wr && !creg_hit),
    .addr (addr),
    .wdata(wdata),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      sel_q  <= 1'b0;
      creg_q <= '0;
    end else begin
      rd_q   <= host_rd;
      sel_q  <= creg_hit;
      creg_q <= creg_v[roff];
    end
  end

  assign rdata    = rd_q ? (sel_q ? creg_q : ram_q) : 8'h00;
  assign rdata_oe = rd_q;
endmodule

// File: rtl/bcdclk_checker.sv
module bcdclk_checker #(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [7:0]    rdata,
  input logic          rdata_oe,
  input logic          stop,
  input logic          sec_pulse,
  input logic          load_stb,
  input logic [CW-1:0] presc_cnt,
  input logic [7:0]    ctrl,
  input logic          creg_wr,
  input logic [7:0]    sec_reg,
  input logic [7:0]    cur_sec
);
  a_r1_read_flag: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n) |=> rdata_oe);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!rdata_oe && rdata == 8'h00));

  a_r7_stop_no_pulse: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sec_pulse);

  a_r8_load_restart: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (presc_cnt == '0));

  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl[6] && !creg_wr) |=> $stable(sec_reg));

  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !load_stb && cur_sec == 8'h59) |=> (cur_sec == 8'h00));
endmodule

bind bcd_clock_sram bcdclk_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .rdata    (rdata),
  .rdata_oe (rdata_oe),
  .stop     (stop),
  .sec_pulse(sec_pulse),
  .load_stb (load_stb),
  .presc_cnt(presc_cnt),
  .ctrl     (ctrl),
  .creg_wr  (creg_wr),
  .sec_reg  (sec_reg),
  .cur_sec  (cur_sec)
);

// File: tb/tb_bcd_clock_sram.sv
`timescale 1ns/1ps
module tb_bcd_clock_sram;
  localparam int DIV = 64;

  logic clk = 0, rst = 1, tick_en = 0, cs_n = 1, oe_n = 1, we_n = 1;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;

  always #2.5 clk = ~clk;

  bcd_clock_sram #(.DIV(DIV), .AW(11)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int ms, mm, mh, mw, md, mo, my;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic step_model();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = mw % 7 + 1; md++;
          if (md > mdays(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin mo = 1; my = (my + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cs_n = 0; we_n = 0; oe_n = 1; addr = a[10:0]; wdata = d[7:0];
    @(negedge clk);
    cs_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = a[10:0];
    @(negedge clk);
    d = rdata;
    cs_n = 1; oe_n = 1;
  endtask

  task automatic load_time(input int s, input int m, input int h, input int w,
                           input int d, input int mon, input int y);
    wr(11'h7F8, 8'h80);
    wr(11'h7F9, bcd(s)); wr(11'h7FA, bcd(m)); wr(11'h7FB, bcd(h));
    wr(11'h7FC, w);      wr(11'h7FD, bcd(d)); wr(11'h7FE, bcd(mon));
    wr(11'h7FF, bcd(y));
    wr(11'h7F8, 8'h00);
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
  endtask

  task automatic advance(input int n);
    repeat (DIV * n + 16) @(negedge clk);
    repeat (n) step_model();
  endtask

  task automatic verify(input string req);
    int v;
    wr(11'h7F8, 8'h40);
    rd(11'h7F9, v); chk({req, " sec"},  v, bcd(ms));
    rd(11'h7FA, v); chk({req, " min"},  v, bcd(mm));
    rd(11'h7FB, v); chk({req, " hour"}, v, bcd(mh));
    rd(11'h7FC, v); chk({req, " wday"}, v, mw);
    rd(11'h7FD, v); chk({req, " date"}, v, bcd(md));
    rd(11'h7FE, v); chk({req, " mon"},  v, bcd(mo));
    rd(11'h7FF, v); chk({req, " year"}, v, bcd(my));
    wr(11'h7F8, 8'h00);
  endtask

  task automatic cal_measure(input int ctl, input int exp_len, input string req);
    int prev, cur, run, intervals, special, bad;
    bit started;
    wr(11'h7F8, ctl);
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = 11'h7F9;
    @(negedge clk);
    prev = rdata; run = 0; started = 0; intervals = 0; special = 0; bad = 0;
    while (intervals < 64) begin
      @(negedge clk);
      cur = rdata; run++;
      if (cur != prev) begin
        if (started) begin
          intervals++;
          if (run == exp_len) special++;
          else if (run != DIV) bad++;
        end
        started = 1; run = 0; prev = cur;
      end
    end
    cs_n = 1; oe_n = 1;
    chk({req, " trimmed seconds"}, special, 1);
    chk({req, " other seconds"}, bad, 0);
    wr(11'h7F8, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int v;
    int ra[24];
    int rdv[24];
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 idle output quiet
    chk("R1 idle oe", rdata_oe, 0);
    chk("R1 idle data", rdata, 0);

    // R3 reset values
    rd(11'h7F8, v); chk("R3 ctrl", v, 8'h00);
    rd(11'h7F9, v); chk("R3 sec", v, 8'h00);
    rd(11'h7FA, v); chk("R3 min", v, 8'h00);
    rd(11'h7FB, v); chk("R3 hour", v, 8'h00);
    rd(11'h7FC, v); chk("R3 wday", v, 8'h01);
    rd(11'h7FD, v); chk("R3 date", v, 8'h01);
    rd(11'h7FE, v); chk("R3 mon", v, 8'h01);
    rd(11'h7FF, v); chk("R3 year", v, 8'h00);

    // R10 no ticks, no progress
    repeat (4 * DIV) @(negedge clk);
    rd(11'h7F9, v); chk("R10 sec held without ticks", v, 8'h00);
    tick_en = 1;

    // R1 storage, including both ends of the plain range
    for (int i = 0; i < 24; i++) begin
      ra[i]  = (i == 0) ? 0 : (i == 1) ? 11'h7F7 : ($urandom % 11'h7F8);
      rdv[i] = $urandom % 256;
      for (int j = 0; j < i; j++) if (ra[j] == ra[i]) ra[i] = (ra[i] + 1) % 11'h7F8;
      wr(ra[i], rdv[i]);
    end
    for (int i = 0; i < 24; i++) begin
      rd(ra[i], v); chk("R1 storage readback", v, rdv[i]);
    end
    @(negedge clk);
    cs_n = 0; oe_n = 0; we_n = 1; addr = 11'h7F7;
    @(negedge clk);
    chk("R1 read flag", rdata_oe, 1);
    cs_n = 1; oe_n = 1;
    @(negedge clk);
    chk("R1 flag drops", rdata_oe, 0);
    chk("R1 data zero when idle", rdata, 0);

    // R2 storage writes leave control alone; direct register access
    rd(11'h7F8, v); chk("R2 ctrl untouched by 0x7F7", v, 8'h00);
    wr(11'h7F8, 8'h40);
    wr(11'h7FA, 8'h37);
    rd(11'h7FA, v); chk("R2 minutes register readback", v, 8'h37);
    wr(11'h7F8, 8'h00);

    // R4 and R5 directed rollovers
    load_time(30, 10, 8, 3, 15, 6, 42); advance(3); verify("R4 plain seconds");
    load_time(58, 59, 23, 7, 31, 12, 99); advance(2); verify("R5 year 99 wrap");
    load_time(59, 59, 23, 2, 28, 2, 24); advance(1); verify("R5 leap Feb 28");
    load_time(59, 59, 23, 3, 29, 2, 24); advance(1); verify("R5 leap Feb 29");
    load_time(59, 59, 23, 3, 28, 2, 23); advance(1); verify("R5 non-leap Feb");
    load_time(59, 59, 23, 4, 30, 4, 10); advance(1); verify("R5 April 30");
    load_time(59, 59, 23, 5, 30, 1, 10); advance(1); verify("R5 Jan 30");
    load_time(57, 59, 9, 1, 12, 3, 0); advance(4); verify("R4 hour carry");

    // R4 and R5 random near-boundary times
    for (int k = 0; k < 20; k++) begin
      int y, mon, d, h, m, s, w, n;
      y   = $urandom % 100;
      mon = 1 + $urandom % 12;
      d   = ($urandom % 2) ? mdays(mon, y) : 1 + $urandom % mdays(mon, y);
      h   = ($urandom % 2) ? 23 : $urandom % 24;
      m   = ($urandom % 2) ? 59 : $urandom % 60;
      s   = 55 + $urandom % 5;
      w   = 1 + $urandom % 7;
      n   = 1 + $urandom % 5;
      load_time(s, m, h, w, d, mon, y);
      advance(n);
      verify("R5 random rollover");
    end

    // R6 freeze holds the visible bytes while counters run
    load_time(30, 20, 10, 1, 5, 5, 5);
    repeat (16) @(negedge clk);
    wr(11'h7F8, 8'h40);
    rd(11'h7F9, v); chk("R6 frozen sec start", v, 8'h30);
    repeat (3 * DIV) @(negedge clk);
    rd(11'h7F9, v); chk("R6 frozen sec held", v, 8'h30);
    wr(11'h7F8, 8'h00);
    repeat (80) @(negedge clk);
    rd(11'h7F9, v); chk("R6 counters kept running", v, 8'h34);

    // R7 stop flag halts the time base
    load_time(0, 0, 0, 1, 1, 1, 0);
    wr(11'h7F9, 8'h92);
    repeat (4 * DIV) @(negedge clk);
    rd(11'h7F9, v); chk("R7 stopped sec byte kept", v, 8'h92);
    rd(11'h7FA, v); chk("R7 stopped minutes kept", v, 8'h00);
    wr(11'h7F9, 8'h12);
    repeat (100) @(negedge clk);
    rd(11'h7F9, v); chk("R7 resumed from held count", v, 8'h01);

    // R8 load bit holds the copy, then loads on its falling edge
    load_time(10, 0, 0, 1, 1, 1, 0);
    wr(11'h7F8, 8'h80);
    wr(11'h7F9, 8'h45);
    repeat (3 * DIV) @(negedge clk);
    rd(11'h7F9, v); chk("R8 copy held during load", v, 8'h45);
    wr(11'h7F8, 8'h00);
    ms = 45;
    advance(1);
    verify("R8 loaded value advances");

    // R9 calibration: fast then slow
    cal_measure(8'h30, DIV - 16, "R9 fast trim");
    cal_measure(8'h10, DIV + 16, "R9 slow trim");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule